// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Receive Queue

This block is a byte-oriented asynchronous serial port for a small 32-bit processor. It sits on a simple load/store bus with one request per cycle, made of address, write strobe, write word, read strobe and a registered read word. Three word registers sit in a 16-byte window at a parameterized base address (default 0x1000_0000). A store to the transmit register puts one byte on the serial line. A load from the receive register takes the oldest byte out of a 16-entry receive queue. A load from the status register reports whether the transmitter is busy and whether the queue holds data.

The line format is fixed: one start bit, eight data bits sent least significant first, no parity, and one stop bit. The default bit period is 434 clocks, which gives 115200 baud from a 50 MHz clock. The bit period is a parameter, so a faster test setting can be used. The receive pin is synchronized with two flops. The receiver checks that the start bit is still low at its midpoint and then samples each data bit and the stop bit at mid-bit. Firmware polls the status word. No interrupts and no flow control are provided.

Top module: `uart_mmio`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `tx_pin` is 1, `rd_data` is zero and a status read returns zero.
- R2: A write with `addr` equal to base+0x0 while the transmitter is idle sends `wr_data[7:0]` on `tx_pin`. The first clock edge after the write starts a low start bit. Bits 0 through 7 follow, then a high stop bit, and each bit lasts `CLKS_PER_BIT` clocks. `tx_pin` is 1 whenever the transmitter is idle.
- R3: Status bit 0 (tx busy) is 1 from the edge that accepts a transmit write until the end of the stop bit, 10×`CLKS_PER_BIT` clocks later. It is 0 after that.
- R4: A transmit write made while status bit 0 is 1 is ignored, and the byte already on the line goes out unchanged.
- R5: A frame received on `rx_pin` with a high stop bit is appended to the receive queue. Status bit 1 (rx valid) is 1 whenever the queue holds at least one byte.
- R6: A read of base+0x4 returns the oldest queued byte in `rd_data[7:0]` with bits 31:8 zero, and removes that byte from the queue.
- R7: A read of base+0x4 while the queue is empty returns zero and leaves the queue unchanged.
- R8: The queue holds 16 bytes in arrival order. A frame that completes while 16 bytes are queued is dropped, and the stored bytes are not affected.
- R9: A low pulse on `rx_pin` shorter than half a bit period is not taken as a start bit. Nothing is queued, and a later valid frame is received correctly.
- R10: Status bits 31:2 read as zero. Reads of base+0x0, base+0xC, of unaligned addresses or of addresses outside the window return zero and do not pop the queue. Writes to any address other than base+0x0 do nothing.
- R11: `rd_data` carries the result in the cycle after `rd_en` is sampled high, and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 32 | Byte address of the bus request |
| wr_en | input | 1 | Write strobe, one cycle per store |
| wr_data | input | 32 | Store data; only bits 7:0 are used |
| rd_en | input | 1 | Read strobe, one cycle per load |
| rd_data | output | 32 | Load data, registered, valid the cycle after `rd_en` |
| rx_pin | input | 1 | Serial receive line, idle high |
| tx_pin | output | 1 | Serial transmit line, idle high |

## Verification
The bench fills the queue with sixteen frames and sends a seventeenth. A design that wrapped on overflow would return the new byte first or lose the oldest one. It reads the empty queue both before and after draining, which exposes a read pointer that moves with no data present. It issues a second store while the first byte is still on the line: a transmitter that accepted it would corrupt the bits sampled at mid-bit. It also drives a short low glitch on the receive line, which a receiver that skips the midpoint check would turn into a phantom 0xFF or a misaligned later frame. Loads outside the window or at unused offsets are placed while a byte waits in the queue, so a loose address decode would pop that byte.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

    localparam int unsigned CLK_HZ   = 50_000_000;
    localparam int unsigned BAUD     = 115_200;
    localparam int unsigned BIT_CLKS = (CLK_HZ + BAUD / 2) / BAUD;   // 434

    localparam logic [31:0] DEFAULT_BASE = 32'h1000_0000;

    localparam int unsigned STAT_TX_BUSY  = 0;
    localparam int unsigned STAT_RX_VALID = 1;

    typedef enum logic [1:0] {
        SEL_TXD  = 2'd0,
        SEL_RXD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_st_e;

    function automatic reg_dec_t decode_addr(input logic [31:0] a, input logic [31:0] base);
        reg_dec_t d;
        d.hit = (a[31:4] == base[31:4]) && (a[1:0] == 2'b00);
        d.sel = reg_sel_e'(a[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_mmio_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = BIT_CLKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       busy,
    output logic       line
);
    localparam int unsigned CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    line_st_e    st;
    logic [CW-1:0] cnt;
    logic [2:0]  bit_idx;
    logic [7:0]  shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LN_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            line    <= 1'b1;
        end else begin
            case (st)
                LN_IDLE: begin
                    line <= 1'b1;
                    if (load) begin
                        shreg <= load_byte;
                        st    <= LN_START;
                        cnt   <= '0;
                        line  <= 1'b0;
                    end
                end
                LN_START: begin
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        st      <= LN_DATA;
                        line    <= shreg[0];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LN_DATA: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        if (bit_idx == 3'd7) begin
                            st   <= LN_STOP;
                            line <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= {1'b0, shreg[7:1]};
                            line    <= shreg[1];
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LN_STOP: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        st  <= LN_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= LN_IDLE;
            endcase
        end
    end

    assign busy = (st != LN_IDLE);

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_mmio_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = BIT_CLKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_async,
    output logic       got_byte,
    output logic [7:0] rx_byte
);
    localparam int unsigned CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);

    logic [1:0]    sync_q;
    logic          rx_s;
    line_st_e      st;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx_async};
    end
    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LN_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            got_byte <= 1'b0;
        end else begin
            got_byte <= 1'b0;
            case (st)
                LN_IDLE: begin
                    cnt <= '0;
                    if (!rx_s) st <= LN_START;
                end
                LN_START: begin
                    if (cnt == MID) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        st      <= rx_s ? LN_IDLE : LN_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LN_DATA: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {rx_s, shreg[7:1]};
                        if (bit_idx == 3'd7) st <= LN_STOP;
                        else                 bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LN_STOP: begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        got_byte <= rx_s;
                        st       <= LN_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= LN_IDLE;
            endcase
        end
    end

    assign rx_byte = shreg;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
    import uart_mmio_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR    = DEFAULT_BASE,
    parameter int unsigned CLKS_PER_BIT = BIT_CLKS,
    parameter int unsigned FIFO_DEPTH   = 16,
    localparam int unsigned LW          = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic        rx_pin,
    output logic        tx_pin
);
    reg_dec_t    dec;
    logic        tx_busy, tx_load;
    logic        rx_got;
    logic [7:0]  rx_byte, fifo_head;
    logic        fifo_empty, fifo_pop, rx_valid;
    logic [LW-1:0] fifo_level;
    logic [31:0] rd_next;
    logic        unused_wdata_hi;

    assign unused_wdata_hi = ^wr_data[31:8];

    assign dec      = decode_addr(addr, BASE_ADDR);
    assign tx_load  = wr_en && dec.hit && (dec.sel == SEL_TXD) && !tx_busy;
    assign fifo_pop = rd_en && dec.hit && (dec.sel == SEL_RXD);
    assign rx_valid = !fifo_empty;

    uart_tx_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_byte (wr_data[7:0]),
        .busy      (tx_busy),
        .line      (tx_pin)
    );

    uart_rx_sampler #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_async (rx_pin),
        .got_byte (rx_got),
        .rx_byte  (rx_byte)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_got),
        .push_data (rx_byte),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .level     (fifo_level)
    );

    always_comb begin
        rd_next = '0;
        if (rd_en && dec.hit) begin
            case (dec.sel)
                SEL_RXD:  rd_next = fifo_empty ? 32'd0 : {24'd0, fifo_head};
                SEL_STAT: begin
                    rd_next[STAT_TX_BUSY]  = tx_busy;
                    rd_next[STAT_RX_VALID] = rx_valid;
                end
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end

endmodule

// File: rtl/uart_mmio_checker.sv
module uart_mmio_checker
    import uart_mmio_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = DEFAULT_BASE,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned LW         = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [31:0]   addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [31:0]   rd_data,
    input logic          tx_pin,
    input logic          tx_busy,
    input logic          rx_valid,
    input logic [LW-1:0] fifo_level
);
    reg_dec_t d;
    logic tx_wr, rx_rd, st_rd;
    assign d     = decode_addr(addr, BASE_ADDR);
    assign tx_wr = wr_en && d.hit && (d.sel == SEL_TXD);
    assign rx_rd = rd_en && d.hit && (d.sel == SEL_RXD);
    assign st_rd = rd_en && d.hit && (d.sel == SEL_STAT);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_pin);

    assert_tx_start_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !tx_busy) |=> (tx_busy && !tx_pin));

    assert_valid_flag_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid == (fifo_level != '0));

    assert_pop_no_grow_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_valid) |=> (fifo_level <= $past(fifo_level)));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !rx_valid) |=> (rd_data == 32'd0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(FIFO_DEPTH));

    assert_status_upper_R10: assert property (@(posedge clk) disable iff (rst)
        st_rd |=> (rd_data[31:2] == 30'd0));

    assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == 32'd0));

endmodule

bind uart_mmio uart_mmio_checker #(
    .BASE_ADDR  (BASE_ADDR),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LW         (LW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .tx_pin     (tx_pin),
    .tx_busy    (tx_busy),
    .rx_valid   (rx_valid),
    .fifo_level (fifo_level)
);

// File: tb/uart_mmio_tb.sv
module uart_mmio_tb;

    localparam int          N     = 16;
    localparam logic [31:0] BASE  = 32'h1000_0000;
    localparam logic [31:0] A_TX  = BASE + 32'h0;
    localparam logic [31:0] A_RX  = BASE + 32'h4;
    localparam logic [31:0] A_ST  = BASE + 32'h8;
    localparam int          NVEC  = 6;
    localparam logic [7:0]  VEC [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rx_pin = 1'b1;
    logic        tx_pin;

    int n_checks = 0;
    int n_err    = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    uart_mmio #(.BASE_ADDR(BASE), .CLKS_PER_BIT(N), .FIFO_DEPTH(16)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_pin(rx_pin), .tx_pin(tx_pin)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // All bus tasks start and end at a falling edge and take one cycle.
    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic send_serial(input logic [7:0] b);
        rx_pin = 1'b0;
        repeat (N) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_pin = b[i];
            repeat (N) @(negedge clk);
        end
        rx_pin = 1'b1;
        repeat (N) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Called half a cycle after the accepting edge, minus cycles already spent.
    task automatic tx_expect(input string tag, input logic [7:0] b, input int used);
        repeat (N / 2 - used) @(negedge clk);
        check({tag, " start bit"}, {31'd0, tx_pin}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (N) @(negedge clk);
            check({tag, " data bit"}, {31'd0, tx_pin}, {31'd0, b[i]});
        end
        repeat (N) @(negedge clk);
        check({tag, " stop bit"}, {31'd0, tx_pin}, 32'd1);
        repeat (N / 2 + 1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 tx idle in reset", {31'd0, tx_pin}, 32'd1);
        check("R1 rd_data in reset", rd_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tx idle after reset", {31'd0, tx_pin}, 32'd1);
        bus_read(A_ST, rv);
        check("R1 status after reset", rv, 32'd0);

        // Vector table: each byte out on TX and in on RX (R2, R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            bus_write(A_TX, {24'hABCDEF, VEC[v]});
            tx_expect("R2 tx frame", VEC[v], 0);
            bus_read(A_ST, rv);
            check("R3 busy cleared after frame", rv, 32'd0);
            send_serial(VEC[v]);
            bus_read(A_ST, rv);
            check("R5 rx valid set", rv, 32'd2);
            bus_read(A_RX, rv);
            check("R6 rx byte", rv, {24'd0, VEC[v]});
            @(negedge clk);
            check("R11 rd_data idle after read", rd_data, 32'd0);
            bus_read(A_ST, rv);
            check("R6 queue empty after pop", rv, 32'd0);
        end

        // R3/R4: busy flag and write while busy
        bus_write(A_TX, 32'h5A);
        bus_write(A_TX, 32'h00);
        bus_read(A_ST, rv);
        check("R3 busy during frame", rv, 32'd1);
        tx_expect("R4 ignored second write", 8'h5A, 2);
        bus_read(A_ST, rv);
        check("R3 busy clears at stop end", rv, 32'd0);
        repeat (N) @(negedge clk);
        check("R4 no second frame", {31'd0, tx_pin}, 32'd1);

        // R7: empty read
        bus_read(A_RX, rv);
        check("R7 empty read zero", rv, 32'd0);
        bus_read(A_ST, rv);
        check("R7 still empty", rv, 32'd0);

        // R8: fill 16, drop the 17th
        for (int k = 0; k < 17; k++) send_serial(8'h30 + 8'(k));
        bus_read(A_ST, rv);
        check("R8 valid when full", rv, 32'd2);
        for (int k = 0; k < 16; k++) begin
            bus_read(A_RX, rv);
            check("R8 order kept", rv, {24'd0, 8'h30 + 8'(k)});
        end
        bus_read(A_RX, rv);
        check("R8 overflow byte dropped", rv, 32'd0);
        bus_read(A_ST, rv);
        check("R8 empty after drain", rv, 32'd0);

        // R9: short glitch rejected, then a real frame
        rx_pin = 1'b0;
        repeat (N / 4) @(negedge clk);
        rx_pin = 1'b1;
        repeat (2 * N) @(negedge clk);
        bus_read(A_ST, rv);
        check("R9 glitch not queued", rv, 32'd0);
        send_serial(8'hC3);
        bus_read(A_RX, rv);
        check("R9 frame after glitch", rv, 32'h0000_00C3);

        // R10: unmapped reads and writes
        bus_write(A_ST, 32'h41);
        bus_write(A_RX, 32'h42);
        bus_write(BASE + 32'hC, 32'h43);
        bus_write(32'h2000_0000, 32'h44);
        repeat (2) @(negedge clk);
        check("R10 stray writes leave tx idle", {31'd0, tx_pin}, 32'd1);
        bus_read(A_ST, rv);
        check("R10 stray writes no busy", rv, 32'd0);
        send_serial(8'h77);
        bus_read(A_TX, rv);
        check("R10 tx reg reads zero", rv, 32'd0);
        bus_read(BASE + 32'hC, rv);
        check("R10 reserved reads zero", rv, 32'd0);
        bus_read(32'h2000_0004, rv);
        check("R10 outside window zero", rv, 32'd0);
        bus_read(BASE + 32'h5, rv);
        check("R10 unaligned read zero", rv, 32'd0);
        bus_read(A_ST, rv);
        check("R10 status upper bits zero", rv, 32'd2);
        bus_read(A_RX, rv);
        check("R10 byte not popped by stray reads", rv, 32'h0000_0077);

        summary();
        $finish;
    end

endmodule